// File: doc/BRIEF.md
# RS-485 Half-Duplex Direction Controller

This block sits next to a UART transmitter and steers an external RS-485 transceiver. It drives two pins, a driver-enable pin and a receiver-enable pin, and each has its own programmable polarity. The transmitter reports whether data is waiting and whether its shifter is idle. The controller reports back whether the transmitter may start shifting. A two-bit transfer mode selects one of three schemes. In the first, the receiver stays on and the driver follows transmit activity. In the second, software sets both enables directly. In the third, a sequencer makes sure only one of the two enables is active at a time, which gives half-duplex operation.

In the sequenced mode the walk runs through six states. It starts in LISTEN (receiver on). On pending data (transition LISTEN->TURN_IN) it drops the receiver and waits out the turnaround time plus one period. It then goes through DE_LEAD, where the driver is on and the block waits the lead delay. In SEND the transmitter is released. When the transmitter is idle with nothing pending (transition SEND->DE_TAIL), it holds the driver for the tail delay. In TURN_OUT both enables are off for the turnaround time plus one period, and the walk returns to LISTEN. A lead or tail delay of zero skips that state: TURN_IN goes straight to SEND, or SEND goes straight to TURN_OUT. All delays are counted in serial clock periods, marked by a one-cycle tick input.

Register writes go to a staging copy. The staging copy becomes the live configuration only while the sequencer rests in LISTEN, so a frame never sees its timing or polarity change part-way through. While RS-485 operation is off, the driver-enable pin carries the UART's RTS signal instead.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, the live configuration is as follows: operation off, mode 0, both polarities active-high (control value 0x6), both permissions 0, all delays 0. So `de_rts_pin` follows `uart_rts`, `re_pin` is 0 and `tx_go` is 1. Register addresses: 0 control (bit 0 enable, bit 1 RE polarity, bit 2 DE polarity, bits 4:3 mode), 1 DE permission (bit 0), 2 RE permission (bit 0), 3 delays (bits 7:0 lead, bits 15:8 tail), 4 turnaround (bits 15:0).
- R2: With operation off, `de_rts_pin` equals `uart_rts`, `re_pin` sits at its inactive level, `tx_go` is 1, and neither the permission bits nor the mode field has any effect.
- R3: A polarity bit of 1 makes its pin high when asserted; 0 makes it low when asserted. The two pins are independent.
- R4: In mode 0, RE is asserted continuously. DE is asserted while `tx_pending` is high or `tx_idle` is low. `tx_go` stays 1. Each enable also requires its permission bit.
- R5: In modes 1 and 3 (software), DE is asserted exactly when the DE permission is 1 and RE exactly when the RE permission is 1. `tx_go` stays 1.
- R6: In mode 2 at rest (LISTEN), RE is asserted, DE is not, and `tx_go` is 0.
- R7: In mode 2, pending data makes RE drop in the next cycle. DE asserts after turnaround+1 ticks, and `tx_go` rises after a further lead-delay ticks.
- R8: In mode 2, `tx_go` stays high until `tx_pending` is low with `tx_idle` high. After that, DE is held for tail-delay ticks, both enables stay off for turnaround+1 ticks, and then RE is re-asserted.
- R9: A lead or tail delay of 0 skips that phase: `tx_go` rises in the same cycle as DE, or DE drops in the same cycle as `tx_go`.
- R10: In mode 2, DE and RE are never asserted together.
- R11: A write made while the sequencer is away from LISTEN has no effect on the pins or the timing until the sequencer is back in LISTEN.
- R12: In mode 2 with the DE permission at 0, DE is never asserted, but the full sequence still gates `tx_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | One-cycle pulse per serial clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tx_pending | input | 1 | Transmitter has data waiting |
| tx_idle | input | 1 | Transmit shifter is idle |
| uart_rts | input | 1 | RTS from the UART, passed out while RS-485 operation is off |
| tx_go | output | 1 | Transmitter may shift data |
| de_rts_pin | output | 1 | Driver-enable pin, shared with RTS |
| re_pin | output | 1 | Receiver-enable pin |

## Verification
The hardest case to reach is a register write landing while a frame is in progress. That write has to be visibly held back, and then visibly applied once the line returns to receive. The stimulus reaches it by driving the transmitter handshake by hand. It stalls in SEND by keeping `tx_idle` low, writes a new DE polarity or a new turnaround value at that moment, and then measures the tick counts of the remaining phases and of the next frame. The lead, tail and turnaround lengths are swept over a small grid that includes zero. Each phase's length is recovered from the pins by counting ticks, and the count is compared with the programmed value.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    localparam int DLY_W  = 8;
    localparam int TAT_W  = 16;
    localparam int CNT_W  = TAT_W + 1;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    localparam int A_CTRL    = 0;
    localparam int A_DE_PERM = 1;
    localparam int A_RE_PERM = 2;
    localparam int A_DELAYS  = 3;
    localparam int A_TURN    = 4;

    typedef enum logic [1:0] {
        XM_FULL   = 2'd0,
        XM_SW     = 2'd1,
        XM_HALF   = 2'd2,
        XM_SW_ALT = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_LISTEN   = 3'd0,
        ST_TURN_IN  = 3'd1,
        ST_DE_LEAD  = 3'd2,
        ST_SEND     = 3'd3,
        ST_DE_TAIL  = 3'd4,
        ST_TURN_OUT = 3'd5
    } dir_state_e;

    typedef struct packed {
        logic             enable;
        logic             re_pol;
        logic             de_pol;
        xfer_mode_e       mode;
        logic             de_perm;
        logic             re_perm;
        logic [DLY_W-1:0] de_lead;
        logic [DLY_W-1:0] de_tail;
        logic [TAT_W-1:0] turn;
    } dir_cfg_t;

endpackage

// File: rtl/rs485_dir_regs.sv
module rs485_dir_regs
    import rs485_dir_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          apply,
    output dir_cfg_t      cfg_live
);

    localparam dir_cfg_t CFG_RESET = '{
        enable:  1'b0,
        re_pol:  1'b1,
        de_pol:  1'b1,
        mode:    XM_FULL,
        de_perm: 1'b0,
        re_perm: 1'b0,
        de_lead: '0,
        de_tail: '0,
        turn:    '0
    };

    dir_cfg_t staged;

    // Staging copy: written at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged <= CFG_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                AW'(A_CTRL): begin
                    staged.enable <= wr_data[0];
                    staged.re_pol <= wr_data[1];
                    staged.de_pol <= wr_data[2];
                    staged.mode   <= xfer_mode_e'(wr_data[4:3]);
                end
                AW'(A_DE_PERM): staged.de_perm <= wr_data[0];
                AW'(A_RE_PERM): staged.re_perm <= wr_data[0];
                AW'(A_DELAYS): begin
                    staged.de_lead <= wr_data[DLY_W-1:0];
                    staged.de_tail <= wr_data[2*DLY_W-1:DLY_W];
                end
                AW'(A_TURN): staged.turn <= wr_data[TAT_W-1:0];
                default: ;
            endcase
        end
    end

    // Live copy: refreshed only while the sequencer rests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_live <= CFG_RESET;
        end else if (apply) begin
            cfg_live <= staged;
        end
    end

endmodule

// File: rtl/rs485_dir_cnt.sv
module rs485_dir_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rs485_dir_seq.sv
module rs485_dir_seq
    import rs485_dir_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  dir_cfg_t      cfg,
    input  logic          tx_pending,
    input  logic          tx_idle,
    input  logic          cnt_zero,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          busy,
    output logic          de_seq,
    output logic          re_seq,
    output logic          go_seq
);

    dir_state_e state_q, state_d;

    logic [CW-1:0] turn_len;
    logic [CW-1:0] lead_len;
    logic [CW-1:0] tail_len;
    logic          frame_done;

    assign turn_len   = CW'(cfg.turn) + CW'(1);
    assign lead_len   = CW'(cfg.de_lead);
    assign tail_len   = CW'(cfg.de_tail);
    assign frame_done = !tx_pending && tx_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_LISTEN: begin
                if (run && tx_pending) begin
                    state_d  = ST_TURN_IN;
                    cnt_load = 1'b1;
                    cnt_val  = turn_len;
                end
            end
            ST_TURN_IN: begin
                if (cnt_zero) begin
                    if (lead_len != '0) begin
                        state_d  = ST_DE_LEAD;
                        cnt_load = 1'b1;
                        cnt_val  = lead_len;
                    end else begin
                        state_d = ST_SEND;
                    end
                end
            end
            ST_DE_LEAD: begin
                if (cnt_zero) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (frame_done) begin
                    cnt_load = 1'b1;
                    if (tail_len != '0) begin
                        state_d = ST_DE_TAIL;
                        cnt_val = tail_len;
                    end else begin
                        state_d = ST_TURN_OUT;
                        cnt_val = turn_len;
                    end
                end
            end
            ST_DE_TAIL: begin
                if (cnt_zero) begin
                    state_d  = ST_TURN_OUT;
                    cnt_load = 1'b1;
                    cnt_val  = turn_len;
                end
            end
            ST_TURN_OUT: begin
                if (cnt_zero) begin
                    state_d = ST_LISTEN;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        de_seq = 1'b0;
        re_seq = 1'b0;
        go_seq = 1'b0;
        unique case (state_q)
            ST_LISTEN:   re_seq = 1'b1;
            ST_TURN_IN:  ;
            ST_DE_LEAD:  de_seq = 1'b1;
            ST_SEND: begin
                de_seq = 1'b1;
                go_seq = 1'b1;
            end
            ST_DE_TAIL:  de_seq = 1'b1;
            ST_TURN_OUT: ;
            default:     ;
        endcase
    end

    assign busy = (state_q != ST_LISTEN);

endmodule

// File: rtl/rs485_dir_pins.sv
module rs485_dir_pins
    import rs485_dir_pkg::*;
(
    input  dir_cfg_t cfg,
    input  logic     de_seq,
    input  logic     re_seq,
    input  logic     go_seq,
    input  logic     tx_pending,
    input  logic     tx_idle,
    input  logic     uart_rts,
    output logic     de_on,
    output logic     re_on,
    output logic     tx_go,
    output logic     de_rts_pin,
    output logic     re_pin
);

    logic de_want;
    logic re_want;
    logic go_want;

    always_comb begin
        de_want = 1'b0;
        re_want = 1'b0;
        go_want = 1'b1;
        unique case (cfg.mode)
            XM_FULL: begin
                de_want = tx_pending || !tx_idle;
                re_want = 1'b1;
            end
            XM_HALF: begin
                de_want = de_seq;
                re_want = re_seq;
                go_want = go_seq;
            end
            XM_SW, XM_SW_ALT: begin
                de_want = 1'b1;
                re_want = 1'b1;
            end
            default: ;
        endcase
    end

    assign de_on      = cfg.enable && cfg.de_perm && de_want;
    assign re_on      = cfg.enable && cfg.re_perm && re_want;
    assign tx_go      = cfg.enable ? go_want : 1'b1;
    assign de_rts_pin = cfg.enable ? (de_on ? cfg.de_pol : !cfg.de_pol) : uart_rts;
    assign re_pin     = re_on ? cfg.re_pol : !cfg.re_pol;

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int ADDR_WIDTH = ADDR_W,
    parameter int DATA_WIDTH = REG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_tick,
    input  logic                  wr_en,
    input  logic [ADDR_WIDTH-1:0] wr_addr,
    input  logic [DATA_WIDTH-1:0] wr_data,
    input  logic                  tx_pending,
    input  logic                  tx_idle,
    input  logic                  uart_rts,
    output logic                  tx_go,
    output logic                  de_rts_pin,
    output logic                  re_pin
);

    localparam int CW = CNT_W;

    dir_cfg_t      cfg;
    logic          busy;
    logic          run;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    logic          de_seq;
    logic          re_seq;
    logic          go_seq;
    logic          de_on;
    logic          re_on;

    assign run = cfg.enable && (cfg.mode == XM_HALF);

    rs485_dir_regs #(
        .AW (ADDR_WIDTH),
        .DW (DATA_WIDTH)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .apply    (!busy),
        .cfg_live (cfg)
    );

    rs485_dir_cnt #(
        .W (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (sclk_tick),
        .zero     (cnt_zero)
    );

    rs485_dir_seq #(
        .CW (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg        (cfg),
        .tx_pending (tx_pending),
        .tx_idle    (tx_idle),
        .cnt_zero   (cnt_zero),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .busy       (busy),
        .de_seq     (de_seq),
        .re_seq     (re_seq),
        .go_seq     (go_seq)
    );

    rs485_dir_pins u_pins (
        .cfg        (cfg),
        .de_seq     (de_seq),
        .re_seq     (re_seq),
        .go_seq     (go_seq),
        .tx_pending (tx_pending),
        .tx_idle    (tx_idle),
        .uart_rts   (uart_rts),
        .de_on      (de_on),
        .re_on      (re_on),
        .tx_go      (tx_go),
        .de_rts_pin (de_rts_pin),
        .re_pin     (re_pin)
    );

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk
    import rs485_dir_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input dir_cfg_t cfg,
    input logic     run,
    input logic     busy,
    input logic     de_on,
    input logic     re_on,
    input logic     tx_go,
    input logic     tx_pending,
    input logic     tx_idle
);

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !(de_on && re_on)); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg)); // R11

    AST_RE_BEFORE_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(de_on)) |-> !$past(re_on)); // R7

    AST_GO_WITH_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_go && cfg.de_perm) |-> de_on); // R7

    AST_GO_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $fell(tx_go)) |-> $past(!tx_pending && tx_idle)); // R8

    AST_NO_GO_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !busy) |-> !tx_go); // R6

endmodule

bind rs485_dir_ctrl rs485_dir_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .run        (run),
    .busy       (busy),
    .de_on      (de_on),
    .re_on      (re_on),
    .tx_go      (tx_go),
    .tx_pending (tx_pending),
    .tx_idle    (tx_idle)
);

// File: tb/rs485_dir_ctrl_bench.sv
module rs485_dir_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tx_pending = 1'b0;
    logic        tx_idle = 1'b1;
    logic        uart_rts = 1'b0;
    logic        tx_go;
    logic        de_rts_pin;
    logic        re_pin;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_ph  = 0;

    rs485_dir_ctrl u_rs485_dir_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_tick  (sclk_tick),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tx_pending (tx_pending),
        .tx_idle    (tx_idle),
        .uart_rts   (uart_rts),
        .tx_go      (tx_go),
        .de_rts_pin (de_rts_pin),
        .re_pin     (re_pin)
    );

    always #4 clk = ~clk;

    // One tick every three clocks, changed away from the sampling edge
    always @(negedge clk) begin
        tick_ph   = (tick_ph == 2) ? 0 : tick_ph + 1;
        sclk_tick = (tick_ph == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic smp();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_addr = 3'(a);
        wr_data = 16'(d);
        wr_en   = 1'b1;
        smp();
        wr_en = 1'b0;
        smp();
        smp();
    endtask

    // Drives one frame through the transmitter handshake and measures phases in ticks
    task automatic run_frame(input logic dp, input logic rp, input int hold,
                             input bit do_wr, input int wa, input int wd,
                             output int t1, output int ta, output int td, output int t2,
                             output bit de_seen, output int send_de, output bit re_in_send,
                             output bit go_held);
        t1 = 0; ta = 0; td = 0; t2 = 0; de_seen = 1'b0;
        tx_idle = 1'b1;
        tx_pending = 1'b1;
        smp();
        while (!((de_rts_pin == dp) || tx_go)) begin
            if (sclk_tick) t1++;
            smp();
        end
        while (!tx_go) begin
            if (de_rts_pin == dp) de_seen = 1'b1;
            if (sclk_tick) ta++;
            smp();
        end
        re_in_send = (re_pin == rp);
        tx_idle = 1'b0;
        if (do_wr) begin
            wr_addr = 3'(wa);
            wr_data = 16'(wd);
            wr_en   = 1'b1;
            smp();
            wr_en = 1'b0;
        end
        repeat (hold) smp();
        tx_pending = 1'b0;
        smp();
        smp();
        send_de = int'(de_rts_pin);
        go_held = tx_go;
        if (de_rts_pin == dp) de_seen = 1'b1;
        tx_idle = 1'b1;
        smp();
        while (de_rts_pin == dp) begin
            if (sclk_tick) td++;
            smp();
        end
        while (re_pin != rp) begin
            if (sclk_tick) t2++;
            smp();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int t1, ta, td, t2, send_de;
        bit de_seen, re_in_send, go_held;
        int tats[3];
        int das[2];
        int dds[2];
        tats = '{0, 1, 3};
        das  = '{0, 2};
        dds  = '{0, 3};

        repeat (3) smp();
        rst_n = 1'b1;
        smp();

        // R1: reset state
        uart_rts = 1'b1;
        smp();
        check("R1 DE pin carries RTS high", int'(de_rts_pin), 1);
        uart_rts = 1'b0;
        smp();
        check("R1 DE pin carries RTS low", int'(de_rts_pin), 0);
        check("R1 RE pin inactive", int'(re_pin), 0);
        check("R1 tx_go open", int'(tx_go), 1);

        // R2: disabled, permissions and mode ignored
        wr(1, 1);
        wr(2, 1);
        wr(0, 'h16);
        tx_pending = 1'b1;
        uart_rts   = 1'b1;
        smp();
        check("R2 DE pin follows RTS high", int'(de_rts_pin), 1);
        check("R2 RE pin inactive", int'(re_pin), 0);
        check("R2 tx_go open", int'(tx_go), 1);
        uart_rts = 1'b0;
        smp();
        check("R2 DE pin follows RTS low", int'(de_rts_pin), 0);
        tx_pending = 1'b0;

        // R3 and R5: software modes over all polarity and permission combinations
        for (int m = 1; m <= 3; m += 2) begin
            for (int dp = 0; dp < 2; dp++) begin
                for (int rp = 0; rp < 2; rp++) begin
                    for (int pd = 0; pd < 2; pd++) begin
                        for (int pr = 0; pr < 2; pr++) begin
                            wr(1, pd);
                            wr(2, pr);
                            wr(0, 1 | (rp << 1) | (dp << 2) | (m << 3));
                            check("R3 R5 DE pin level", int'(de_rts_pin), (pd != 0) ? dp : 1 - dp);
                            check("R3 R5 RE pin level", int'(re_pin), (pr != 0) ? rp : 1 - rp);
                            check("R5 tx_go open", int'(tx_go), 1);
                        end
                    end
                end
            end
        end

        // R4: mode 0
        wr(1, 1);
        wr(2, 1);
        wr(0, 'h07);
        tx_pending = 1'b0;
        tx_idle    = 1'b1;
        smp();
        check("R4 DE off when quiet", int'(de_rts_pin), 0);
        check("R4 RE on", int'(re_pin), 1);
        tx_pending = 1'b1;
        smp();
        check("R4 DE on with pending data", int'(de_rts_pin), 1);
        check("R4 RE stays on", int'(re_pin), 1);
        tx_pending = 1'b0;
        tx_idle    = 1'b0;
        smp();
        check("R4 DE on while shifting", int'(de_rts_pin), 1);
        check("R4 tx_go open", int'(tx_go), 1);
        tx_idle = 1'b1;
        smp();
        check("R4 DE off after frame", int'(de_rts_pin), 0);

        // R6-R10: mode 2 timing sweep
        wr(0, 'h17);
        foreach (tats[i]) begin
            foreach (das[j]) begin
                foreach (dds[k]) begin
                    wr(4, tats[i]);
                    wr(3, das[j] | (dds[k] << 8));
                    check("R6 RE on at rest", int'(re_pin), 1);
                    check("R6 DE off at rest", int'(de_rts_pin), 0);
                    check("R6 tx_go closed at rest", int'(tx_go), 0);
                    run_frame(1'b1, 1'b1, 2, 1'b0, 0, 0, t1, ta, td, t2,
                              de_seen, send_de, re_in_send, go_held);
                    check("R7 turn-in ticks", t1, tats[i] + 1);
                    if (das[j] == 0) check("R9 lead skipped", ta, 0);
                    else             check("R7 lead ticks", ta, das[j]);
                    check("R10 RE off during send", int'(re_in_send), 0);
                    check("R8 DE held while shifting", send_de, 1);
                    check("R8 tx_go held while shifting", int'(go_held), 1);
                    if (dds[k] == 0) check("R9 tail skipped", td, 0);
                    else             check("R8 tail ticks", td, dds[k]);
                    check("R8 turn-out ticks", t2, tats[i] + 1);
                    check("R8 RE back on", int'(re_pin), 1);
                end
            end
        end

        // R12: DE permission off, sequence still gates the transmitter
        wr(1, 0);
        wr(4, 1);
        wr(3, 2 | (1 << 8));
        run_frame(1'b1, 1'b1, 2, 1'b0, 0, 0, t1, ta, td, t2,
                  de_seen, send_de, re_in_send, go_held);
        check("R12 DE never asserted", int'(de_seen), 0);
        check("R12 tx_go delayed by turn-in and lead", t1, 4);
        check("R12 tx_go held while shifting", int'(go_held), 1);
        wr(1, 1);

        // R11: polarity write mid-frame is held
        run_frame(1'b1, 1'b1, 3, 1'b1, 0, 'h13, t1, ta, td, t2,
                  de_seen, send_de, re_in_send, go_held);
        check("R11 old DE polarity kept mid-frame", send_de, 1);
        check("R11 turn-out unchanged", t2, 2);
        smp();
        check("R11 new DE polarity after frame", int'(de_rts_pin), 1);
        wr(0, 'h17);

        // R11: turnaround write mid-frame is held
        run_frame(1'b1, 1'b1, 2, 1'b1, 4, 4, t1, ta, td, t2,
                  de_seen, send_de, re_in_send, go_held);
        check("R11 turn-out uses old turnaround", t2, 2);
        smp();
        run_frame(1'b1, 1'b1, 2, 1'b0, 0, 0, t1, ta, td, t2,
                  de_seen, send_de, re_in_send, go_held);
        check("R11 next frame uses new turnaround", t1, 5);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule